// File: doc/BRIEF.md
# SHAKE Squeeze Output Stage

This block is the last stage of a SHAKE128/SHAKE256 hashing pipeline. It keeps a local copy of each 1600-bit state that the permutation stage hands over. It then streams the rate part of that copy out as 64-bit words over a valid/ready handshake. The total output length, in bits, and the security mode are sampled with the first state of an operation. The mode sets how many words one state yields: 21 for SHAKE128 and 17 for SHAKE256.

When the words of one state are used up and output is still owed, the stage raises a squeeze request and waits for a freshly permuted state. The stage does not care whether that state was already waiting or arrives later. The final word is flagged as last. When the length is not a whole number of words, the unused high-order bytes of the final word are forced to zero. After the last word is taken, the stage goes back to idle and can accept the first state of the next operation. The permutation stage can therefore overlap its work with the output of the previous block.

Top module: `shake_squeeze`

## Requirements
- R1: After reset, `out_valid` and `sqz_req` are 0 and `st_ready` is 1.
- R2: In idle, a state is accepted in the cycle where `st_valid` and `st_ready` are both 1. If `out_len` is non-zero, `out_valid` is 1 in the next cycle.
- R3: The words of a state come out in lane order. Word k of a state is `st_data[64k+63:64k]`, for k = 0, 1, 2, and so on.
- R4: `mode_sel` = 0 selects SHAKE128, which gives at most 21 words per state. `mode_sel` = 1 selects SHAKE256, which gives at most 17.
- R5: When the last word of a state has been accepted and output is still owed, `sqz_req` and `st_ready` are 1 and `out_valid` is 0. Once a new state has been accepted, output continues with lane 0 of that state.
- R6: An operation produces exactly ceil(`out_len`/64) words. `out_last` is 1 on the final word only.
- R7: When `out_len` mod 64 is a non-zero number r, bits 63 down to r of the final word are 0. The remaining bits equal the lane.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R9: In the cycle after the final word is accepted, `out_valid` and `sqz_req` are 0 and `st_ready` is 1.
- R10: A state accepted in idle with `out_len` = 0 produces no word, and the stage stays idle.
- R11: `mode_sel` and `out_len` are sampled only when the first state of an operation is accepted. Changes to them later in the operation have no effect on the words, the flags or the squeeze points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | A permuted state is offered on `st_data` |
| st_ready | output | 1 | The stage can take a state (idle or waiting for a squeeze) |
| st_data | input | 1600 | Permuted state; lane k is bits 64k+63 down to 64k |
| mode_sel | input | 1 | 0 = SHAKE128, 1 = SHAKE256; sampled with the first state |
| out_len | input | 16 | Output length in bits, a multiple of 8; sampled with the first state |
| sqz_req | output | 1 | A further permutation is needed to continue output |
| out_valid | output | 1 | `out_data` holds a word |
| out_ready | input | 1 | The consumer takes the word this cycle |
| out_data | output | 64 | Output word, masked on the final partial word |
| out_last | output | 1 | The current word is the last of the operation |

## Verification
The lengths are picked so that the counts reveal an off-by-one at a rate boundary. Some lengths are exactly one rate of each mode, and others are one byte beyond it: one extra word, and a squeeze request where the exact fit has none. Long multi-block lengths in both modes check that the squeeze point depends on the mode. Single-byte and odd-byte lengths test the mask. Each state carries a distinct value per lane, so a wrong lane, a stale block or a skipped refill shows up directly in the data. Irregular back-pressure and scrambled mode and length inputs in the middle of an operation show that the words hold and that the sampled settings do not drift.

// File: rtl/shake_sq_pkg.sv
package shake_sq_pkg;

   typedef enum logic {
      SQ_MODE_LO = 1'b0,
      SQ_MODE_HI = 1'b1
   } sq_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_EMIT = 2'd1,
      SQ_WAIT = 2'd2
   } sq_phase_e;

   // Words in the rate of a sponge whose capacity is twice the security level.
   function automatic int rate_words(input int state_w, input int sec_bits, input int word_w);
      return (state_w - 2 * sec_bits) / word_w;
   endfunction

endpackage

// File: rtl/sq_state_buf.sv
module sq_state_buf #(
   parameter int WORD_W = 64,
   parameter int LANES  = 25,
   parameter int IDX_W  = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [WORD_W*LANES-1:0]   state_in,
   input  logic [IDX_W-1:0]          lane_sel,
   output logic [WORD_W-1:0]         lane_out
);

   logic [WORD_W-1:0] lane_q [LANES];

   if ((1 << IDX_W) < LANES) begin : g_bad_idx
      $error("sq_state_buf: IDX_W too narrow for LANES");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q[g] <= '0;
         end else if (load) begin
            lane_q[g] <= state_in[g*WORD_W +: WORD_W];
         end
      end
   end

   assign lane_out = lane_q[lane_sel];

   assert_sel_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(lane_sel) < LANES)
      else $error("lane select beyond state");

endmodule

// File: rtl/sq_tracker.sv
module sq_tracker
   import shake_sq_pkg::*;
#(
   parameter int WORD_W  = 64,
   parameter int LEN_W   = 16,
   parameter int IDX_W   = 5,
   parameter int RATE_LO = 21,
   parameter int RATE_HI = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              advance,
   input  logic [LEN_W-1:0]  len_in,
   input  sq_mode_e          mode_in,
   output logic [IDX_W-1:0]  lane_idx,
   output logic [LEN_W-1:0]  rem_bits,
   output logic              is_last,
   output logic              rate_done
);

   localparam logic [LEN_W-1:0] WORD_BITS = LEN_W'(WORD_W);
   localparam logic [IDX_W-1:0] LAST_LO   = IDX_W'(RATE_LO - 1);
   localparam logic [IDX_W-1:0] LAST_HI   = IDX_W'(RATE_HI - 1);

   sq_mode_e mode_q;

   if (RATE_LO < 1 || RATE_HI < 1) begin : g_bad_rate
      $error("sq_tracker: rates must be positive");
   end
   if ((1 << IDX_W) < RATE_LO || (1 << IDX_W) < RATE_HI) begin : g_bad_idx
      $error("sq_tracker: IDX_W too narrow for the rate");
   end

   assign is_last   = (rem_bits <= WORD_BITS);
   assign rate_done = (lane_idx == ((mode_q == SQ_MODE_HI) ? LAST_HI : LAST_LO));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_idx <= '0;
         rem_bits <= '0;
         mode_q   <= SQ_MODE_LO;
      end else if (start) begin
         lane_idx <= '0;
         rem_bits <= len_in;
         mode_q   <= mode_in;
      end else if (advance) begin
         lane_idx <= rate_done ? '0 : lane_idx + 1'b1;
         rem_bits <= is_last ? '0 : rem_bits - WORD_BITS;
      end
   end

   assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(lane_idx) < ((mode_q == SQ_MODE_HI) ? RATE_HI : RATE_LO))
      else $error("lane index beyond the rate of the mode");

   assert_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (rem_bits == $past(len_in)))
      else $error("length not captured at start");

   assert_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !advance) |=> ($stable(rem_bits) && $stable(mode_q) && $stable(lane_idx)))
      else $error("tracker state moved without a start or an accepted word");

endmodule

// File: rtl/sq_mask.sv
module sq_mask #(
   parameter int WORD_W = 64,
   parameter int LEN_W  = 16,
   parameter int GRAN   = 8
) (
   input  logic [WORD_W-1:0] word_in,
   input  logic [LEN_W-1:0]  rem_bits,
   output logic [WORD_W-1:0] word_out
);

   localparam int NGRAN = WORD_W / GRAN;

   if (GRAN < 1 || (WORD_W % GRAN) != 0) begin : g_bad_gran
      $error("sq_mask: GRAN must divide WORD_W");
   end
   if ((1 << (LEN_W - 1)) < WORD_W) begin : g_bad_len
      $error("sq_mask: LEN_W cannot hold one word length");
   end

   if (GRAN == 1) begin : g_bitwise
      logic [WORD_W-1:0] keep;
      always_comb begin
         if (rem_bits >= LEN_W'(WORD_W)) begin
            keep = '1;
         end else begin
            keep = ({{(WORD_W-1){1'b0}}, 1'b1} << rem_bits) - 1'b1;
         end
      end
      assign word_out = word_in & keep;
   end else begin : g_granular
      for (genvar g = 0; g < NGRAN; g++) begin : g_part
         assign word_out[g*GRAN +: GRAN] =
            (rem_bits > LEN_W'(g * GRAN)) ? word_in[g*GRAN +: GRAN] : '0;
      end
   end

endmodule

// File: rtl/shake_squeeze.sv
module shake_squeeze
   import shake_sq_pkg::*;
#(
   parameter int WORD_W    = 64,
   parameter int STATE_W   = 1600,
   parameter int LEN_W     = 16,
   parameter int SEC_LO    = 128,
   parameter int SEC_HI    = 256,
   parameter int MASK_GRAN = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               st_valid,
   output logic               st_ready,
   input  logic [STATE_W-1:0] st_data,
   input  logic               mode_sel,
   input  logic [LEN_W-1:0]   out_len,
   output logic               sqz_req,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [WORD_W-1:0]  out_data,
   output logic               out_last
);

   localparam int LANES   = STATE_W / WORD_W;
   localparam int IDX_W   = $clog2(LANES);
   localparam int RATE_LO = rate_words(STATE_W, SEC_LO, WORD_W);
   localparam int RATE_HI = rate_words(STATE_W, SEC_HI, WORD_W);

   if ((STATE_W % WORD_W) != 0) begin : g_bad_state
      $error("shake_squeeze: STATE_W must be a multiple of WORD_W");
   end
   if (((2 * SEC_LO) % WORD_W) != 0 || ((2 * SEC_HI) % WORD_W) != 0) begin : g_bad_sec
      $error("shake_squeeze: capacities must be whole words");
   end
   if (RATE_LO > LANES || RATE_HI < 1) begin : g_bad_rate
      $error("shake_squeeze: rate outside the state");
   end

   sq_phase_e         phase_q, phase_d;
   logic              take, start, refill, load, advance;
   logic [IDX_W-1:0]  lane_idx;
   logic [LEN_W-1:0]  rem_bits;
   logic              is_last, rate_done;
   logic [WORD_W-1:0] lane_word;

   assign st_ready  = (phase_q == SQ_IDLE) || (phase_q == SQ_WAIT);
   assign sqz_req   = (phase_q == SQ_WAIT);
   assign out_valid = (phase_q == SQ_EMIT);
   assign out_last  = out_valid && is_last;

   assign take    = st_valid && st_ready;
   assign start   = take && (phase_q == SQ_IDLE) && (out_len != '0);
   assign refill  = take && (phase_q == SQ_WAIT);
   assign load    = start || refill;
   assign advance = out_valid && out_ready;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         SQ_IDLE: if (start)   phase_d = SQ_EMIT;
         SQ_EMIT: if (advance) phase_d = is_last ? SQ_IDLE : (rate_done ? SQ_WAIT : SQ_EMIT);
         SQ_WAIT: if (refill)  phase_d = SQ_EMIT;
         default:              phase_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= SQ_IDLE;
      else        phase_q <= phase_d;
   end

   sq_state_buf #(
      .WORD_W (WORD_W),
      .LANES  (LANES),
      .IDX_W  (IDX_W)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .state_in (st_data),
      .lane_sel (lane_idx),
      .lane_out (lane_word)
   );

   sq_tracker #(
      .WORD_W  (WORD_W),
      .LEN_W   (LEN_W),
      .IDX_W   (IDX_W),
      .RATE_LO (RATE_LO),
      .RATE_HI (RATE_HI)
   ) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .advance   (advance),
      .len_in    (out_len),
      .mode_in   (sq_mode_e'(mode_sel)),
      .lane_idx  (lane_idx),
      .rem_bits  (rem_bits),
      .is_last   (is_last),
      .rate_done (rate_done)
   );

   sq_mask #(
      .WORD_W (WORD_W),
      .LEN_W  (LEN_W),
      .GRAN   (MASK_GRAN)
   ) u_mask (
      .word_in  (lane_word),
      .rem_bits (rem_bits),
      .word_out (out_data)
   );

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)))
      else $error("word changed under back-pressure");

   assert_req_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sqz_req |-> (!out_valid && st_ready))
      else $error("output active while a squeeze is pending");

   assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid)
      else $error("last flag without a word");

   assert_idle_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> (!out_valid && st_ready && !sqz_req))
      else $error("stage not idle after the final word");

   assert_mask_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (rem_bits < LEN_W'(WORD_W))) |-> ((out_data >> rem_bits) == '0))
      else $error("bits past the length are not zero");

   assert_empty_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_q == SQ_IDLE) && st_valid && (out_len == '0)) |=> !out_valid)
      else $error("zero-length request produced a word");

endmodule

// File: tb/shake_squeeze_test.sv
module shake_squeeze_test;

   localparam int NVEC = 9;
   // {mode(8), length(16), expected words(8), expected squeezes(8)}
   localparam logic [39:0] VEC [NVEC] = '{
      {8'd0, 16'd1344, 8'd21, 8'd0},
      {8'd0, 16'd1352, 8'd22, 8'd1},
      {8'd1, 16'd1088, 8'd17, 8'd0},
      {8'd1, 16'd1096, 8'd18, 8'd1},
      {8'd0, 16'd8,    8'd1,  8'd0},
      {8'd1, 16'd200,  8'd4,  8'd0},
      {8'd0, 16'd3000, 8'd47, 8'd2},
      {8'd1, 16'd2560, 8'd40, 8'd2},
      {8'd1, 16'd456,  8'd8,  8'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_valid = 1'b0;
   logic          st_ready;
   logic [1599:0] st_data = '0;
   logic          mode_sel = 1'b0;
   logic [15:0]   out_len = '0;
   logic          sqz_req;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [63:0]   out_data;
   logic          out_last;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   shake_squeeze uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_valid  (st_valid),
      .st_ready  (st_ready),
      .st_data   (st_data),
      .mode_sel  (mode_sel),
      .out_len   (out_len),
      .sqz_req   (sqz_req),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_last  (out_last)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] lane_val(input int seed, input int blk, input int lane);
      return {32'(seed) ^ 32'(blk * 40503), 16'(lane * 331 + 7), 8'(blk + 1), 8'(lane + 1)};
   endfunction

   function automatic logic [1599:0] mk_block(input int seed, input int blk);
      logic [1599:0] d;
      for (int l = 0; l < 25; l++) d[l*64 +: 64] = lane_val(seed, blk, l);
      return d;
   endfunction

   task automatic run_op(input int vi, input bit m, input int len, input int seed,
                         input int exp_words, input int exp_sq);
      int words = 0, blk = 0, lane = 0, rem = len, sq = 0, cyc = 0;
      int rate = m ? 17 : 21;
      bit done = 0, held = 0;
      logic [63:0] held_d = '0, expw;
      @(negedge clk);
      chk(st_ready == 1'b1, "R2 ready in idle", 64'(st_ready), 64'd1);
      mode_sel = m; out_len = 16'(len);
      st_valid = 1'b1; st_data = mk_block(seed, 0);
      @(negedge clk);
      st_valid = 1'b0;
      // R11: scramble the sampled settings for the rest of the operation
      mode_sel = ~m; out_len = 16'd8;
      chk(out_valid == 1'b1, "R2 first word valid", 64'(out_valid), 64'd1);
      while (!done && cyc < 5000) begin
         cyc++;
         st_valid  = 1'b0;
         out_ready = 1'b0;
         if (held) chk(out_valid && out_data == held_d, "R8 hold under back-pressure", out_data, held_d);
         held = 0;
         if (sqz_req) begin
            chk(!out_valid && st_ready, "R5 quiet while squeezing", 64'(out_valid), 64'd0);
            chk(lane == rate, "R4 words per state", 64'(lane), 64'(rate));
            sq++; blk++; lane = 0;
            st_valid = 1'b1; st_data = mk_block(seed, blk);
         end else if (out_valid) begin
            out_ready = ((cyc + vi) % 3) != 0;
            expw = lane_val(seed, blk, lane);
            if (rem < 64) expw = expw & ((64'd1 << rem) - 64'd1);
            if (out_ready) begin
               if (rem < 64) chk(out_data == expw, "R7 masked final word", out_data, expw);
               else          chk(out_data == expw, "R3 lane word", out_data, expw);
               chk(out_last == (rem <= 64), "R6 last flag", 64'(out_last), 64'(rem <= 64));
               words++; lane++; rem -= 64;
               if (rem <= 0) done = 1;
            end else begin
               held = 1; held_d = out_data;
            end
         end
         @(negedge clk);
      end
      st_valid = 1'b0; out_ready = 1'b0;
      chk(!out_valid && st_ready && !sqz_req, "R9 idle after final word", 64'(out_valid), 64'd0);
      chk(words == exp_words, "R6 word count", 64'(words), 64'(exp_words));
      chk(sq == exp_sq, "R5 squeeze count", 64'(sq), 64'(exp_sq));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!out_valid && !sqz_req && st_ready, "R1 state in reset", {out_valid, sqz_req, st_ready}, 64'b001);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && !sqz_req && st_ready, "R1 state after reset", {out_valid, sqz_req, st_ready}, 64'b001);

      for (int i = 0; i < NVEC; i++) begin
         run_op(i, VEC[i][32], int'(VEC[i][31:16]), i * 1000 + 17,
                int'(VEC[i][15:8]), int'(VEC[i][7:0]));
      end

      // R10: zero length produces nothing
      @(negedge clk);
      mode_sel = 1'b0; out_len = 16'd0; st_valid = 1'b1; st_data = mk_block(5, 0);
      @(negedge clk);
      st_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk(!out_valid && st_ready && !sqz_req, "R10 zero length stays idle", 64'(out_valid), 64'd0);
         @(negedge clk);
      end

      // R1: reset in the middle of an operation returns to idle
      mode_sel = 1'b1; out_len = 16'd640; st_valid = 1'b1; st_data = mk_block(9, 0);
      @(negedge clk);
      st_valid = 1'b0;
      chk(out_valid == 1'b1, "R2 word after start", 64'(out_valid), 64'd1);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!out_valid && !sqz_req && st_ready, "R1 reset mid operation", {out_valid, sqz_req, st_ready}, 64'b001);
      rst_n = 1'b1;
      @(negedge clk);

      // after the abort a fresh short operation runs cleanly
      run_op(NVEC, 1'b0, 136, 4242, 3, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule